// File: doc/BRIEF.md
# Descriptor-Chained Multi-Channel DMA Controller

This block moves words out of memory for several independent channels. Software gives a channel the address of its first buffer descriptor and starts it. From then on the controller works on its own. It reads a descriptor to learn a buffer address and a word count. It streams that buffer word by word to its data output, tagged with the channel number. When the buffer is used up, it follows the descriptor's link to the next one. A link of zero ends the chain. At that point the channel raises its done flag and stops.

Each channel keeps its own saved context: a chain pointer, a buffer pointer and a remaining count. Only the channel that holds the memory port is updated at any moment. For that reason one pointer incrementer and one count decrementer are shared by all channels. The channels take turns round-robin. A turn is either one data word or one whole three-word descriptor fetch. Memory is reached through a word-wide read port with a request/ready handshake, and addresses count in words.

Top module: `dma_chain_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mem_req`, `dout_valid`, `busy_o` and `done_o` are all zero.
- R2: A `cfg_valid` pulse naming an idle channel loads `cfg_ptr` as that channel's chain pointer. In the next cycle the channel's `busy_o` bit is set and its `done_o` bit is cleared. A `cfg_valid` pulse naming a busy channel has no effect.
- R3: A descriptor at word address P is three words. P holds the buffer address. P+1 holds the word count in bits 15:0, and its upper bits are ignored. P+2 holds the next-descriptor address. All three words are read in P, P+1, P+2 order within one turn.
- R4: A buffer at address B with count N is read at B, B+1, … B+N-1. Each word appears on `dout_data` with `dout_valid` high and `dout_ch` set to the channel, in the same cycle that `mem_ready` accepts the read.
- R5: A descriptor whose count is zero moves no data. The controller goes on to that descriptor's next-descriptor address.
- R6: When a buffer is finished, or a zero-count descriptor has been read, and the next-descriptor address is zero, the channel's `done_o` bit is set and its `busy_o` bit is cleared.
- R7: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` until a cycle in which `mem_ready` is high.
- R8: After a turn ends, there is one cycle with `mem_req` low. The next turn then goes to the first busy channel after the last served one, in cyclic order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Start request for channel `cfg_ch` |
| cfg_ch | input | CHW | Channel to start |
| cfg_ptr | input | AW | Address of the first descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Word address of the read |
| mem_rdata | input | AW | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts the read and returns data |
| dout_valid | output | 1 | A buffer word is on `dout_data` |
| dout_ch | output | CHW | Channel that owns the word |
| dout_data | output | AW | Buffer word |
| busy_o | output | NCH | Channel is running its chain |
| done_o | output | NCH | Channel reached the end of its chain (sticky) |

## Verification
The hardest case to reach is a start request aimed at a channel that is still busy. It has to land while that channel is in the middle of its chain and the other channel is competing for the port. The bench issues such a request during a run with randomly stalled `mem_ready`. Two things then show that the request had no effect: the cycle model, which ignores it, keeps matching the design, and the number of words that come out is unchanged. Zero-count descriptors are placed both at the head and in the middle of chains, so that skipping is seen right after a start and during a run.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_MOVE  = 1'b1
    } phase_e;

    typedef enum logic {
        SQ_ARB = 1'b0,
        SQ_ACC = 1'b1
    } seq_e;

    localparam int DESC_WORDS = 3;
    localparam logic [1:0] STEP_BUF  = 2'd0;
    localparam logic [1:0] STEP_CNT  = 2'd1;
    localparam logic [1:0] STEP_LINK = 2'd2;

    typedef struct packed {
        logic   busy;
        logic   done;
        phase_e phase;
    } chan_flags_t;

endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [CHW-1:0] last,
    output logic           found,
    output logic [CHW-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(last) + k) % NCH;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = CHW'(idx);
            end
        end
    end

    // R8
    pick_is_requester_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> req[pick]);

endmodule

// File: rtl/dma_step_unit.sv
module dma_step_unit #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [AW-1:0] ptr_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] ptr_next,
    output logic [CW-1:0] cnt_next,
    output logic          cnt_last
);
    always_comb begin
        ptr_next = ptr_in + AW'(1);
        cnt_next = cnt_in - CW'(1);
        cnt_last = (cnt_in == CW'(1));
    end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_valid,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [AW-1:0]  cfg_ptr,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic [AW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           dout_valid,
    output logic [CHW-1:0] dout_ch,
    output logic [AW-1:0]  dout_data,
    output logic [NCH-1:0] busy_o,
    output logic [NCH-1:0] done_o
);
    chan_flags_t    fl_q   [NCH];
    logic [AW-1:0]  pptr_q [NCH];
    logic [AW-1:0]  bptr_q [NCH];
    logic [CW-1:0]  cnt_q  [NCH];
    seq_e           sq_q;
    logic [CHW-1:0] gnt_q, last_q;
    logic [1:0]     step_q;

    logic [NCH-1:0] busy_vec;
    logic           arb_found;
    logic [CHW-1:0] arb_pick;
    logic [AW-1:0]  cur_ptr, ptr_inc;
    logic [CW-1:0]  cnt_dec;
    logic           cnt_last;
    phase_e         cur_phase;
    logic           ack;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            busy_vec[i] = fl_q[i].busy;
            done_o[i]   = fl_q[i].done;
        end
    end
    assign busy_o = busy_vec;

    dma_rr_arb #(.NCH(NCH)) u_arb (
        .clk(clk), .rst(rst), .req(busy_vec), .last(last_q),
        .found(arb_found), .pick(arb_pick)
    );

    assign cur_phase = fl_q[gnt_q].phase;
    assign cur_ptr   = (cur_phase == PH_FETCH) ? pptr_q[gnt_q] : bptr_q[gnt_q];

    dma_step_unit #(.AW(AW), .CW(CW)) u_step (
        .ptr_in(cur_ptr), .cnt_in(cnt_q[gnt_q]),
        .ptr_next(ptr_inc), .cnt_next(cnt_dec), .cnt_last(cnt_last)
    );

    assign mem_req    = (sq_q == SQ_ACC);
    assign mem_addr   = cur_ptr;
    assign ack        = mem_req && mem_ready;
    assign dout_valid = ack && (cur_phase == PH_MOVE);
    assign dout_ch    = gnt_q;
    assign dout_data  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q   <= SQ_ARB;
            gnt_q  <= '0;
            last_q <= CHW'(NCH - 1);
            step_q <= STEP_BUF;
            for (int i = 0; i < NCH; i++) begin
                fl_q[i]   <= '{busy: 1'b0, done: 1'b0, phase: PH_FETCH};
                pptr_q[i] <= '0;
                bptr_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
        end else begin
            case (sq_q)
                SQ_ARB: begin
                    if (arb_found) begin
                        gnt_q  <= arb_pick;
                        step_q <= STEP_BUF;
                        sq_q   <= SQ_ACC;
                    end
                end
                default: begin
                    if (mem_ready) begin
                        if (cur_phase == PH_FETCH) begin
                            case (step_q)
                                STEP_BUF: begin
                                    bptr_q[gnt_q] <= mem_rdata;
                                    pptr_q[gnt_q] <= ptr_inc;
                                    step_q        <= STEP_CNT;
                                end
                                STEP_CNT: begin
                                    cnt_q[gnt_q]  <= mem_rdata[CW-1:0];
                                    pptr_q[gnt_q] <= ptr_inc;
                                    step_q        <= STEP_LINK;
                                end
                                default: begin
                                    pptr_q[gnt_q] <= mem_rdata;
                                    sq_q          <= SQ_ARB;
                                    last_q        <= gnt_q;
                                    if (cnt_q[gnt_q] != '0) begin
                                        fl_q[gnt_q].phase <= PH_MOVE;
                                    end else if (mem_rdata == '0) begin
                                        fl_q[gnt_q].busy <= 1'b0;
                                        fl_q[gnt_q].done <= 1'b1;
                                    end
                                end
                            endcase
                        end else begin
                            bptr_q[gnt_q] <= ptr_inc;
                            cnt_q[gnt_q]  <= cnt_dec;
                            sq_q          <= SQ_ARB;
                            last_q        <= gnt_q;
                            if (cnt_last) begin
                                fl_q[gnt_q].phase <= PH_FETCH;
                                if (pptr_q[gnt_q] == '0) begin
                                    fl_q[gnt_q].busy <= 1'b0;
                                    fl_q[gnt_q].done <= 1'b1;
                                end
                            end
                        end
                    end
                end
            endcase

            if (cfg_valid && (int'(cfg_ch) < NCH) && !fl_q[cfg_ch].busy) begin
                fl_q[cfg_ch].busy  <= 1'b1;
                fl_q[cfg_ch].done  <= 1'b0;
                fl_q[cfg_ch].phase <= PH_FETCH;
                pptr_q[cfg_ch]     <= cfg_ptr;
            end
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R4
    dout_src_chk: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> (mem_req && mem_ready));

    // R8
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !(cur_phase == PH_FETCH && step_q != STEP_LINK)) |=> !mem_req);

    // R3
    fetch_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && cur_phase == PH_FETCH && step_q != STEP_LINK) |=> (mem_req && $stable(gnt_q)));

    for (genvar c = 0; c < NCH; c++) begin : g_chan_chk
        // R6
        done_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(done_o[c]) |-> $fell(busy_o[c]));
        // R2
        start_load_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_valid && int'(cfg_ch) == c && !busy_o[c]) |=> (busy_o[c] && !done_o[c]));
    end

endmodule

// File: tb/dma_chain_ctrl_test.sv
module dma_chain_ctrl_test;
    localparam int NCH = 2;
    localparam int AW  = 32;
    localparam int CHW = 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_valid = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [AW-1:0]  cfg_ptr = '0;
    logic           mem_req;
    logic [AW-1:0]  mem_addr;
    logic [AW-1:0]  mem_rdata;
    logic           mem_ready = 1'b0;
    logic           dout_valid;
    logic [CHW-1:0] dout_ch;
    logic [AW-1:0]  dout_data;
    logic [NCH-1:0] busy_o, done_o;

    dma_chain_ctrl #(.NCH(NCH), .AW(AW), .CW(16)) uut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ch(cfg_ch), .cfg_ptr(cfg_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dout_valid(dout_valid), .dout_ch(dout_ch), .dout_data(dout_data),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int words [NCH];
    bit rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] dmem [int unsigned];

    function automatic logic [31:0] memrd(logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        return a * 32'h9E37 + 32'd11;
    endfunction

    assign mem_rdata = memrd(mem_addr);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_st, m_g, m_last, m_step, st0;
    bit          m_busy [NCH];
    bit          m_done [NCH];
    bit          m_move [NCH];
    bit          old_busy [NCH];
    logic [31:0] m_pp [NCH];
    logic [31:0] m_bp [NCH];
    int          m_cnt [NCH];
    logic [31:0] rd;

    function automatic logic [31:0] m_addr();
        return m_move[m_g] ? m_bp[m_g] : m_pp[m_g];
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_st = 0; m_g = 0; m_last = NCH - 1; m_step = 0;
            for (int i = 0; i < NCH; i++) begin
                m_busy[i] = 0; m_done[i] = 0; m_move[i] = 0;
                m_pp[i] = 0; m_bp[i] = 0; m_cnt[i] = 0;
            end
        end else begin
            st0 = m_st;
            for (int i = 0; i < NCH; i++) old_busy[i] = m_busy[i];
            if (st0 == 1 && mem_ready) begin
                rd = memrd(m_addr());
                if (!m_move[m_g]) begin
                    if (m_step == 0) begin m_bp[m_g] = rd; m_pp[m_g] += 1; m_step = 1; end
                    else if (m_step == 1) begin m_cnt[m_g] = int'(rd[15:0]); m_pp[m_g] += 1; m_step = 2; end
                    else begin
                        m_pp[m_g] = rd; m_st = 0; m_last = m_g;
                        if (m_cnt[m_g] != 0) m_move[m_g] = 1;
                        else if (rd == 0) begin m_busy[m_g] = 0; m_done[m_g] = 1; end
                    end
                end else begin
                    m_bp[m_g] += 1; m_cnt[m_g] -= 1; m_st = 0; m_last = m_g;
                    if (m_cnt[m_g] == 0) begin
                        m_move[m_g] = 0;
                        if (m_pp[m_g] == 0) begin m_busy[m_g] = 0; m_done[m_g] = 1; end
                    end
                end
            end
            if (cfg_valid && !old_busy[cfg_ch]) begin
                m_busy[cfg_ch] = 1; m_done[cfg_ch] = 0; m_move[cfg_ch] = 0; m_pp[cfg_ch] = cfg_ptr;
            end
            if (st0 == 0) begin
                for (int k = 1; k <= NCH; k++) begin
                    if (m_st == 0 && old_busy[(m_last + k) % NCH]) begin
                        m_g = (m_last + k) % NCH; m_st = 1; m_step = 0;
                    end
                end
            end
        end
    end

    // ready driver
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 mem_req", 32'(mem_req), 32'(m_st == 1));
            if (m_st == 1) chk("R3 mem_addr", mem_addr, m_addr());
            chk("R4 dout_valid", 32'(dout_valid), 32'(m_st == 1 && mem_ready && m_move[m_g]));
            if (m_st == 1 && mem_ready && m_move[m_g]) begin
                chk("R4 dout_data", dout_data, memrd(m_addr()));
                chk("R8 dout_ch", 32'(dout_ch), 32'(m_g));
            end
            for (int i = 0; i < NCH; i++) begin
                chk("R6 busy", 32'(busy_o[i]), 32'(m_busy[i]));
                chk("R6 done", 32'(done_o[i]), 32'(m_done[i]));
            end
            if (dout_valid) words[dout_ch]++;
        end
    end

    task automatic start(int ch, logic [31:0] p);
        @(posedge clk); #2;
        cfg_valid = 1'b1; cfg_ch = CHW'(ch); cfg_ptr = p;
        @(posedge clk); #2;
        cfg_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy_o !== '0 && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) begin n_cmp++; n_bad++; $display("FAIL watchdog busy=%b expected=0", busy_o); end
    endtask

    initial begin
        // ch0: 3 words, zero-count descriptor mid-chain, then 2 words
        dmem[100] = 1000; dmem[101] = 32'h0003_0003; dmem[102] = 110;
        dmem[110] = 2000; dmem[111] = 0;             dmem[112] = 120;
        dmem[120] = 3000; dmem[121] = 2;             dmem[122] = 0;
        // ch1: single word
        dmem[200] = 4000; dmem[201] = 1;             dmem[202] = 0;
        // restart chains
        dmem[300] = 5000; dmem[301] = 4;             dmem[302] = 0;
        dmem[400] = 7000; dmem[401] = 32'hFFFF_0000; dmem[402] = 410;
        dmem[410] = 6000; dmem[411] = 1;             dmem[412] = 0;
        for (int i = 0; i < NCH; i++) words[i] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 dout_valid", 32'(dout_valid), 0);
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_req after reset", 32'(mem_req), 0);

        rdy_rand = 1'b1;
        start(0, 100);
        start(1, 200);
        repeat (6) @(posedge clk);
        start(0, 300); // R2: channel 0 busy, must be ignored
        wait_idle();
        chk("R6 done both", 32'(done_o), 32'h3);
        chk("R5 ch0 word count", 32'(words[0]), 5);
        chk("R2 ch1 word count", 32'(words[1]), 1);

        rdy_rand = 1'b0;
        start(1, 300);
        @(negedge clk);
        chk("R2 done1 cleared", 32'(done_o[1]), 0);
        start(0, 400); // R5 zero count at head
        wait_idle();
        chk("R4 ch1 word count", 32'(words[1]), 5);
        chk("R5 ch0 word count", 32'(words[0]), 6);
        chk("R6 done final", 32'(done_o), 32'h3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog cycles=%0d expected<50000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule